// File: doc/BRIEF.md
# RTC Alarm Comparator With Wildcard Fields

This block decides when a real-time clock's alarm has gone off. After each completed time update, the clock core pulses a strobe. On that strobe the block compares the current seconds, minutes and hours bytes with three alarm bytes. A field also matches when its alarm byte lies between C0h and FFh, which acts as a wildcard. When all three fields match on the same strobe, a sticky alarm flag is set.

The flag stays set until software reads the flag register, which the host side signals with a one-cycle read strobe. An interrupt request is the alarm flag gated by an alarm-interrupt enable. The comparison works on the raw stored bytes, so the alarm bytes must use the same BCD/binary and 12/24-hour coding as the time bytes.

The flag is held by a two-state machine. FLAG_IDLE means no alarm is pending. FLAG_HELD means an alarm is pending. The transition ARM (FLAG_IDLE to FLAG_HELD) happens on an update strobe with all fields matching. The transition ACK (FLAG_HELD to FLAG_IDLE) happens on a read strobe when no matching update arrives in the same cycle. Every other case keeps the state.

Top module: `rtc_alarm_match`

## Requirements
- R1: After reset, alm_flag and alm_irq are both 0.
- R2: A field matches when its alarm byte equals its time byte bit for bit. There is no BCD or 12/24-hour conversion, so 12h does not match 92h.
- R3: An alarm byte whose bits [7:6] are both 1 (C0h to FFh) matches any time byte. BFh is not a wildcard.
- R4: A clock edge with upd_done high and all three fields matching sets alm_flag after that edge. If any field mismatches, the flag stays clear.
- R5: Without upd_done, matching inputs leave alm_flag unchanged.
- R6: A clock edge with flag_rd high and no matching update clears alm_flag after that edge.
- R7: When flag_rd and a matching upd_done occur on the same edge, alm_flag stays or becomes 1.
- R8: alm_irq is 1 exactly when alm_flag and alm_ie are both 1. It follows alm_ie in the same cycle, with no register in between.
- R9: Once set, alm_flag stays 1 through later updates that do not match, until a read clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| upd_done | input | 1 | One-cycle pulse after each completed time update |
| sec_now | input | 8 | Current seconds byte |
| min_now | input | 8 | Current minutes byte |
| hr_now | input | 8 | Current hours byte |
| sec_alarm | input | 8 | Seconds alarm byte |
| min_alarm | input | 8 | Minutes alarm byte |
| hr_alarm | input | 8 | Hours alarm byte |
| alm_ie | input | 1 | Alarm interrupt enable |
| flag_rd | input | 1 | One-cycle pulse when the flag register is read |
| alm_flag | output | 1 | Sticky alarm flag |
| alm_irq | output | 1 | Alarm interrupt request |

## Verification
The flag sits one register away from its strobes. Set and clear both appear after the edge that samples upd_done or flag_rd. The bench drives inputs on the falling edge, holds each strobe for one full cycle, and samples the flag at the next falling edge. The interrupt request is combinational from the flag and alm_ie, so it is checked in the same half cycle in which alm_ie changes. Tests that expect no effect (R5, R9) sample the flag at the same point after the stimulus, before the next read.

// File: rtl/rtc_alm_pkg.sv
package rtc_alm_pkg;
    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned FIELD_CNT = 3;

    // Pending-alarm state of the flag register
    typedef enum logic {
        FLAG_IDLE = 1'b0,
        FLAG_HELD = 1'b1
    } flag_state_e;
endpackage

// File: rtl/rtc_alm_field_cmp.sv
module rtc_alm_field_cmp #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] now_b,
    input  logic [W-1:0] alm_b,
    output logic         hit
);
    logic wild;

    // Top two bits set marks the don't-care range
    always_comb begin
        wild = &alm_b[W-1 -: 2];
        hit  = wild || (alm_b == now_b);
    end
endmodule

// File: rtl/rtc_alm_flag_fsm.sv
module rtc_alm_flag_fsm
    import rtc_alm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic upd_done,
    input  logic all_hit,
    input  logic flag_rd,
    output logic flag
);
    flag_state_e cur_st, nxt_st;
    logic        arm_ev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_st <= FLAG_IDLE;
        else        cur_st <= nxt_st;
    end

    always_comb begin
        arm_ev = upd_done && all_hit;
        nxt_st = cur_st;
        unique case (cur_st)
            FLAG_IDLE: if (arm_ev)             nxt_st = FLAG_HELD; // ARM
            FLAG_HELD: if (flag_rd && !arm_ev) nxt_st = FLAG_IDLE; // ACK
        endcase
    end

    always_comb begin
        unique case (cur_st)
            FLAG_IDLE: flag = 1'b0;
            FLAG_HELD: flag = 1'b1;
        endcase
    end

    // R4, R7
    hit_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_done && all_hit) |=> flag);
    // R6
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_rd && !upd_done) |=> !flag);
    // R5
    rise_needs_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(upd_done && all_hit));
    // R9
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !flag_rd) |=> flag);
endmodule

// File: rtl/rtc_alm_irq_gate.sv
module rtc_alm_irq_gate (
    input  logic flag,
    input  logic ie,
    output logic irq
);
    always_comb irq = flag && ie;
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
    import rtc_alm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_done,
    input  logic [BYTE_W-1:0] sec_now,
    input  logic [BYTE_W-1:0] min_now,
    input  logic [BYTE_W-1:0] hr_now,
    input  logic [BYTE_W-1:0] sec_alarm,
    input  logic [BYTE_W-1:0] min_alarm,
    input  logic [BYTE_W-1:0] hr_alarm,
    input  logic              alm_ie,
    input  logic              flag_rd,
    output logic              alm_flag,
    output logic              alm_irq
);
    logic [BYTE_W-1:0]    now_arr [FIELD_CNT];
    logic [BYTE_W-1:0]    alm_arr [FIELD_CNT];
    logic [FIELD_CNT-1:0] fld_hit;
    logic                 all_hit;

    always_comb begin
        now_arr[0] = sec_now;   alm_arr[0] = sec_alarm;
        now_arr[1] = min_now;   alm_arr[1] = min_alarm;
        now_arr[2] = hr_now;    alm_arr[2] = hr_alarm;
        all_hit    = &fld_hit;
    end

    for (genvar f = 0; f < FIELD_CNT; f++) begin : g_field
        rtc_alm_field_cmp #(.W(BYTE_W)) cmp_i (
            .now_b (now_arr[f]),
            .alm_b (alm_arr[f]),
            .hit   (fld_hit[f])
        );
    end

    rtc_alm_flag_fsm fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_done (upd_done),
        .all_hit  (all_hit),
        .flag_rd  (flag_rd),
        .flag     (alm_flag)
    );

    rtc_alm_irq_gate gate_i (
        .flag (alm_flag),
        .ie   (alm_ie),
        .irq  (alm_irq)
    );

    // R3
    wild_sec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&sec_alarm[7:6]) |-> fld_hit[0]);
    // R3
    wild_hr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&hr_alarm[7:6]) |-> fld_hit[2]);
    // R2
    exact_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&min_alarm[7:6]) && (min_alarm != min_now)) |-> !all_hit);
endmodule

// File: tb/rtc_alarm_match_tb_top.sv
module rtc_alarm_match_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic upd_done = 1'b0, alm_ie = 1'b0, flag_rd = 1'b0;
    logic [7:0] sec_now = 8'h0, min_now = 8'h0, hr_now = 8'h0;
    logic [7:0] sec_alarm = 8'h0, min_alarm = 8'h0, hr_alarm = 8'h0;
    logic alm_flag, alm_irq;
    int checks = 0, failures = 0;

    always #4 clk = ~clk;

    rtc_alarm_match dut_i (.*);

    // {sec_now, min_now, hr_now, sec_alarm, min_alarm, hr_alarm, expect}
    localparam int NV = 10;
    localparam logic [48:0] VEC [NV] = '{
        {8'h30, 8'h15, 8'h08, 8'h30, 8'h15, 8'h08, 1'b1},  // R2
        {8'h30, 8'h15, 8'h08, 8'h31, 8'h15, 8'h08, 1'b0},  // R4
        {8'h30, 8'h15, 8'h08, 8'hC0, 8'h15, 8'h08, 1'b1},  // R3
        {8'h30, 8'h15, 8'h08, 8'hFF, 8'hFF, 8'hFF, 1'b1},  // R3
        {8'h30, 8'h15, 8'h08, 8'hC0, 8'h16, 8'hFF, 1'b0},  // R4
        {8'h59, 8'h59, 8'h23, 8'hBF, 8'h59, 8'h23, 1'b0},  // R3 BF
        {8'h00, 8'h00, 8'h00, 8'h00, 8'hE5, 8'h00, 1'b1},  // R3
        {8'h45, 8'h30, 8'h92, 8'h45, 8'h30, 8'h12, 1'b0},  // R2 raw
        {8'h45, 8'h30, 8'h92, 8'h45, 8'h30, 8'h92, 1'b1},  // R2
        {8'h12, 8'h34, 8'h56, 8'h12, 8'h34, 8'hD0, 1'b1}   // R3
    };

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic do_update();
        upd_done = 1'b1;
        @(negedge clk);
        upd_done = 1'b0;
    endtask

    task automatic do_read();
        flag_rd = 1'b1;
        @(negedge clk);
        flag_rd = 1'b0;
    endtask

    task automatic set_match(input logic hit);
        sec_now = 8'h10; min_now = 8'h20; hr_now = 8'h05;
        sec_alarm = hit ? 8'h10 : 8'h11; min_alarm = 8'h20; hr_alarm = 8'h05;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk("watchdog", 1'b1, 1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 flag", alm_flag, 1'b0);
        chk("R1 irq", alm_irq, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 flag after release", alm_flag, 1'b0);

        for (int i = 0; i < NV; i++) begin
            {sec_now, min_now, hr_now, sec_alarm, min_alarm, hr_alarm} = VEC[i][48:1];
            do_update();
            chk($sformatf("R2/R3/R4 vec%0d", i), alm_flag, VEC[i][0]);
            do_read();
            chk("R6 clear", alm_flag, 1'b0);
        end

        // R5: matching inputs, no strobe
        set_match(1'b1);
        repeat (3) @(negedge clk);
        chk("R5 no strobe", alm_flag, 1'b0);

        // R9: sticky through non-matching update
        do_update();
        chk("R4 set", alm_flag, 1'b1);
        set_match(1'b0);
        do_update();
        chk("R9 sticky", alm_flag, 1'b1);
        repeat (2) @(negedge clk);
        chk("R9 held", alm_flag, 1'b1);

        // R8: interrupt gating
        chk("R8 irq off", alm_irq, 1'b0);
        alm_ie = 1'b1; #1;
        chk("R8 irq on", alm_irq, 1'b1);
        do_read();
        chk("R8 irq drops with flag", alm_irq, 1'b0);

        // R7: read and matching update on the same edge
        set_match(1'b1);
        flag_rd = 1'b1;
        do_update();
        flag_rd = 1'b0;
        chk("R7 collision from idle", alm_flag, 1'b1);
        flag_rd = 1'b1;
        do_update();
        flag_rd = 1'b0;
        chk("R7 collision while held", alm_flag, 1'b1);
        chk("R8 irq with ie", alm_irq, 1'b1);
        alm_ie = 1'b0; #1;
        chk("R8 ie low", alm_irq, 1'b0);

        // R6: read with a non-matching update
        set_match(1'b0);
        flag_rd = 1'b1;
        do_update();
        flag_rd = 1'b0;
        chk("R6 clear with miss", alm_flag, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule